// File: doc/BRIEF.md
# UART Register Bank with Interrupt Identification

This block is the processor-facing side of a classic asynchronous serial controller. A host reaches it through an 8-bit data bus and a 3-bit register address. It holds the configuration registers: line format, modem outputs, interrupt enables, FIFO control and the 16-bit baud divisor. It passes transmit bytes to the serializer and returns received bytes, line status and modem status to the host. One address can select a different register for a read than for a write. A divisor-access bit in the line format register switches addresses 0 and 1 over to the divisor bytes.

The serializers, FIFOs and baud generator are outside the block. They send it level and pulse status signals and receive its control outputs. The block also combines the enabled, pending interrupt sources into a prioritized identification code and a single interrupt output.

Top module: `uart_regbank`

## Requirements
- R1: After reset, the line format, enable, modem control, FIFO control and divisor registers are all 0. The identification register reads 0x01. With `thr_empty`=1, `tx_empty`=1 and `rx_ready`=0, line status reads 0x60. `irq_out` is 0.
- R2: With line format bit 7 clear, a write to address 0 loads `tx_byte` and pulses `tx_load` for one cycle in the cycle after the write. A read of address 0 returns `rx_byte` and raises `rx_pop` in the same cycle.
- R3: With line format bit 7 set, address 0 reads and writes the divisor low byte and address 1 the divisor high byte, shown on `divisor`. In this mode `tx_load` does not pulse and the enable register is left unchanged.
- R4: Address 1 holds the interrupt enables: bit 0 receive data, bit 1 transmit holding empty, bit 2 line errors, bit 3 modem changes. Bits 7:4 are not stored and read as 0.
- R5: A read of address 2 returns the identification register. Bit 0 is 0 while an interrupt is pending. Bits 2:1 name the source: 11 line error, 10 receive data, 01 transmit holding empty, 00 modem change (also 00 when nothing is pending). Bits 7:3 are 0. `irq_out` is 1 exactly when an interrupt is pending.
- R6: When several enabled sources are pending, only the highest is reported. The order, highest first, is line error, then receive data (`rx_ready` level), then transmit holding empty, then modem change.
- R7: The transmit-empty source becomes pending in the cycle after a rising edge of `thr_empty`. It is cleared by a write of the transmit byte, or by a read of address 2 while that source is the one reported.
- R8: Address 5 returns line status: bit 0 `rx_ready`, bits 4:1 sticky flags from `line_err_ev` bits 0..3 (overrun, parity, framing, break), bit 5 `thr_empty`, bit 6 `tx_empty`. A read clears bits 4:1. An event arriving in the same cycle as the read is kept.
- R9: Address 3 is the full 8-bit line format register, shown on `line_ctrl`. Address 4 stores 6 modem control bits, shown on `modem_ctrl`, and bits 7:6 read as 0.
- R10: Address 6 returns modem status. Bits 7:4 hold the registered levels of `modem_in` (bit 0 CTS, 1 DSR, 2 RI, 3 DCD). Bits 3:0 are set when the matching line changes, and a read clears them.
- R11: A write to address 2 loads `fifo_ctrl` and pulses `fifo_wr` in the next cycle. It does not alter what address 2 reads back. Address 7 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Register access select |
| wr_en | input | 1 | Write strobe (with cs) |
| rd_en | input | 1 | Read strobe (with cs) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| rx_byte | input | 8 | Byte at the head of the receive path |
| rx_ready | input | 1 | Receive data available (level) |
| line_err_ev | input | 4 | Error pulses: overrun, parity, framing, break |
| thr_empty | input | 1 | Transmit holding space empty (level) |
| tx_empty | input | 1 | Transmitter fully idle (level) |
| modem_in | input | 4 | Modem input levels: CTS, DSR, RI, DCD |
| tx_byte | output | 8 | Byte handed to the transmit path |
| tx_load | output | 1 | One-cycle load pulse for tx_byte |
| rx_pop | output | 1 | Receive byte consumed |
| divisor | output | 16 | Baud divisor |
| line_ctrl | output | 8 | Line format register |
| modem_ctrl | output | 6 | Modem control outputs |
| fifo_ctrl | output | 8 | FIFO control value |
| fifo_wr | output | 1 | One-cycle pulse after a FIFO control write |
| irq_out | output | 1 | Interrupt request |

## Verification
The assertions assume that `line_err_ev` is a pulse that the serial side drives only when an error occurs. They also assume that `thr_empty` changes only on clock edges, so its registered copy marks every rising edge exactly once. The bench drives all inputs on falling edges and never asserts read and write together. Each event lasts a single cycle, and when an event coincides with a read it is applied in that read's cycle on purpose. With this stimulus the clear-versus-set rules in the status logic can be stated as simple next-cycle properties.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
  localparam int DW = 8;
  localparam int AW = 3;

  typedef enum logic [1:0] {
    SRC_MODEM = 2'b00,
    SRC_THRE  = 2'b01,
    SRC_RX    = 2'b10,
    SRC_LINE  = 2'b11
  } src_e;

  localparam logic [AW-1:0] A_DATA = 3'd0;
  localparam logic [AW-1:0] A_IER  = 3'd1;
  localparam logic [AW-1:0] A_IIR  = 3'd2;
  localparam logic [AW-1:0] A_LCR  = 3'd3;
  localparam logic [AW-1:0] A_MCR  = 3'd4;
  localparam logic [AW-1:0] A_LSR  = 3'd5;
  localparam logic [AW-1:0] A_MSR  = 3'd6;

  // identification byte: active-low pending flag in bit 0, source in 2:1
  function automatic logic [DW-1:0] iir_pack(input logic pend, input src_e src);
    return {5'b0, src, ~pend};
  endfunction

  function automatic logic [DW-1:0] lsr_pack(input logic rdy, input logic [3:0] err,
                                             input logic thre, input logic temt);
    return {1'b0, temt, thre, err, rdy};
  endfunction
endpackage

// File: rtl/uart_rb_status.sv
module uart_rb_status #(
  parameter int NERR  = 4,
  parameter int NLINE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_lsr,
  input  logic             rd_msr,
  input  logic [NERR-1:0]  err_ev,
  input  logic [NLINE-1:0] lines,
  output logic [NERR-1:0]  err_q,
  output logic [NLINE-1:0] delta_q,
  output logic [NLINE-1:0] level_q
);
  logic [NLINE-1:0] line_chg;
  logic [NLINE-1:0] delta_nxt;
  logic             err_quiet;

  assign line_chg  = lines ^ level_q;
  assign err_quiet = (err_ev == '0);

  for (genvar i = 0; i < NLINE; i++) begin : g_delta
    assign delta_nxt[i] = (delta_q[i] & ~rd_msr) | line_chg[i];
    // R10
    msr_delta_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_chg[i] |=> delta_q[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q   <= '0;
      delta_q <= '0;
      level_q <= '0;
    end else begin
      err_q   <= (rd_lsr ? '0 : err_q) | err_ev;
      delta_q <= delta_nxt;
      level_q <= lines;
    end
  end

  // R8
  lsr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr && err_quiet) |=> (err_q == '0));
  // R8
  lsr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr && !err_quiet) |=> (err_q == $past(err_ev)));
endmodule

// File: rtl/uart_rb_irq.sv
module uart_rb_irq
  import uart_rb_pkg::*;
#(
  parameter int IER_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IER_W-1:0] ier,
  input  logic             err_any,
  input  logic             rx_rdy,
  input  logic             thr_empty,
  input  logic             thr_wr,
  input  logic             iir_rd,
  input  logic             modem_any,
  output src_e             src,
  output logic             pend,
  output logic             thre_pend
);
  logic thr_prev;
  logic thre_rise;
  logic thre_clr;
  logic line_req, rx_req, thre_req, modem_req;

  assign thre_rise = thr_empty & ~thr_prev;
  assign thre_clr  = thr_wr | (iir_rd & pend & (src == SRC_THRE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_prev  <= 1'b1;
      thre_pend <= 1'b0;
    end else begin
      thr_prev  <= thr_empty;
      thre_pend <= thre_rise | (thre_pend & ~thre_clr);
    end
  end

  assign line_req  = ier[2] & err_any;
  assign rx_req    = ier[0] & rx_rdy;
  assign thre_req  = ier[1] & thre_pend;
  assign modem_req = ier[3] & modem_any;

  always_comb begin
    pend = 1'b1;
    if (line_req)       src = SRC_LINE;
    else if (rx_req)    src = SRC_RX;
    else if (thre_req)  src = SRC_THRE;
    else begin
      src  = SRC_MODEM;
      pend = modem_req;
    end
  end

  // R6
  line_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ier[2] && err_any) |-> (pend && src == SRC_LINE));
  // R7
  thre_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thre_rise |=> thre_pend);
  // R7
  thre_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !thre_rise) |=> !thre_pend);
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_rb_pkg::*;
#(
  parameter int IER_W = 4,
  parameter int MCR_W = 6,
  parameter int NERR  = 4,
  parameter int NLINE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [DW-1:0]    rx_byte,
  input  logic             rx_ready,
  input  logic [NERR-1:0]  line_err_ev,
  input  logic             thr_empty,
  input  logic             tx_empty,
  input  logic [NLINE-1:0] modem_in,
  output logic [DW-1:0]    tx_byte,
  output logic             tx_load,
  output logic             rx_pop,
  output logic [2*DW-1:0]  divisor,
  output logic [DW-1:0]    line_ctrl,
  output logic [MCR_W-1:0] modem_ctrl,
  output logic [DW-1:0]    fifo_ctrl,
  output logic             fifo_wr,
  output logic             irq_out
);
  localparam int IER_PAD = DW - IER_W;
  localparam int MCR_PAD = DW - MCR_W;

  logic [DW-1:0]    lcr_q, dll_q, dlm_q, fcr_q;
  logic [IER_W-1:0] ier_q;
  logic [MCR_W-1:0] mcr_q;
  logic             dlab, wr_s, rd_s, thr_wr;
  logic [NERR-1:0]  err_q;
  logic [NLINE-1:0] delta_q, level_q;
  src_e             src;
  logic             pend, thre_pend;

  assign dlab   = lcr_q[DW-1];
  assign wr_s   = cs & wr_en;
  assign rd_s   = cs & rd_en;
  assign thr_wr = wr_s & (addr == A_DATA) & ~dlab;
  assign rx_pop = rd_s & (addr == A_DATA) & ~dlab;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lcr_q   <= '0;
      dll_q   <= '0;
      dlm_q   <= '0;
      fcr_q   <= '0;
      ier_q   <= '0;
      mcr_q   <= '0;
      tx_byte <= '0;
      tx_load <= 1'b0;
      fifo_wr <= 1'b0;
    end else begin
      tx_load <= thr_wr;
      fifo_wr <= wr_s & (addr == A_IIR);
      if (thr_wr) tx_byte <= wdata;
      if (wr_s) begin
        case (addr)
          A_DATA: if (dlab) dll_q <= wdata;
          A_IER:  if (dlab) dlm_q <= wdata; else ier_q <= wdata[IER_W-1:0];
          A_IIR:  fcr_q <= wdata;
          A_LCR:  lcr_q <= wdata;
          A_MCR:  mcr_q <= wdata[MCR_W-1:0];
          default: ;
        endcase
      end
    end
  end

  uart_rb_status #(.NERR(NERR), .NLINE(NLINE)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_lsr  (rd_s & (addr == A_LSR)),
    .rd_msr  (rd_s & (addr == A_MSR)),
    .err_ev  (line_err_ev),
    .lines   (modem_in),
    .err_q   (err_q),
    .delta_q (delta_q),
    .level_q (level_q)
  );

  uart_rb_irq #(.IER_W(IER_W)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ier       (ier_q),
    .err_any   (|err_q),
    .rx_rdy    (rx_ready),
    .thr_empty (thr_empty),
    .thr_wr    (thr_wr),
    .iir_rd    (rd_s & (addr == A_IIR)),
    .modem_any (|delta_q),
    .src       (src),
    .pend      (pend),
    .thre_pend (thre_pend)
  );

  always_comb begin
    case (addr)
      A_DATA:  rdata = dlab ? dll_q : rx_byte;
      A_IER:   rdata = dlab ? dlm_q : {{IER_PAD{1'b0}}, ier_q};
      A_IIR:   rdata = iir_pack(pend, src);
      A_LCR:   rdata = lcr_q;
      A_MCR:   rdata = {{MCR_PAD{1'b0}}, mcr_q};
      A_LSR:   rdata = lsr_pack(rx_ready, err_q, thr_empty, tx_empty);
      A_MSR:   rdata = {level_q, delta_q};
      default: rdata = '0;
    endcase
  end

  assign divisor    = {dlm_q, dll_q};
  assign line_ctrl  = lcr_q;
  assign modem_ctrl = mcr_q;
  assign fifo_ctrl  = fcr_q;
  assign irq_out    = pend;

  // R2
  tx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_s && addr == A_DATA && !dlab) |=> (tx_load && tx_byte == $past(wdata)));
  // R3
  dlab_no_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_s && addr == A_DATA && dlab) |=> !tx_load);
  // R3
  dlab_ier_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_s && addr == A_IER && dlab) |=> $stable(ier_q));
  // R11
  fifo_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_s && addr == A_IIR) |=> (fifo_wr && fifo_ctrl == $past(wdata)));
endmodule

// File: tb/sim_uart_regbank.sv
`timescale 1ns/100ps
module sim_uart_regbank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 0, wr_en = 0, rd_en = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rdata, rx_byte = 0;
  logic       rx_ready = 0, thr_empty = 1, tx_empty = 1;
  logic [3:0] line_err_ev = 0, modem_in = 0;
  logic [7:0] tx_byte, line_ctrl, fifo_ctrl;
  logic       tx_load, rx_pop, fifo_wr, irq_out;
  logic [15:0] divisor;
  logic [5:0] modem_ctrl;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_regbank u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rx_byte(rx_byte),
    .rx_ready(rx_ready), .line_err_ev(line_err_ev), .thr_empty(thr_empty),
    .tx_empty(tx_empty), .modem_in(modem_in), .tx_byte(tx_byte),
    .tx_load(tx_load), .rx_pop(rx_pop), .divisor(divisor),
    .line_ctrl(line_ctrl), .modem_ctrl(modem_ctrl), .fifo_ctrl(fifo_ctrl),
    .fifo_wr(fifo_wr), .irq_out(irq_out)
  );

  // behavioural model of interrupt state, updated on every rising edge
  int m_ier = 0, m_err = 0, m_delta = 0, m_lvl = 0, m_lcr = 0;
  bit m_thre = 0, m_prev = 1;

  function automatic int m_code();
    if ((m_ier & 4) && m_err != 0) return 3;
    if ((m_ier & 1) && rx_ready)   return 2;
    if ((m_ier & 2) && m_thre)     return 1;
    if ((m_ier & 8) && m_delta != 0) return 0;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ier = 0; m_err = 0; m_delta = 0; m_lvl = 0; m_lcr = 0;
      m_thre = 0; m_prev = 1;
    end else begin
      automatic int code = m_code();
      automatic bit rd = cs && rd_en;
      automatic bit wr = cs && wr_en;
      automatic bit dl = (m_lcr >= 128);
      automatic bit clr = (wr && addr == 0 && !dl) || (rd && addr == 2 && code == 1);
      m_thre = (thr_empty && !m_prev) || (m_thre && !clr);
      m_prev = thr_empty;
      m_err = ((rd && addr == 5) ? 0 : m_err) | line_err_ev;
      m_delta = ((rd && addr == 6) ? 0 : m_delta) | (modem_in ^ m_lvl);
      m_lvl = modem_in;
      if (wr && addr == 1 && !dl) m_ier = wdata & 15;
      if (wr && addr == 3) m_lcr = wdata;
    end
  end

  // R5: per-cycle comparison of the interrupt line against the model
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      total++;
      if (irq_out !== (m_code() >= 0)) begin
        bad++;
        $display("FAIL R5 irq_out actual=%0b expected=%0b", irq_out, m_code() >= 0);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1; wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    cs = 0; wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    cs = 1; rd_en = 1; addr = a;
    #0.5;
    chk(tag, rdata, exp);
    @(negedge clk);
    cs = 0; rd_en = 0;
  endtask

  task automatic thr_bounce();
    @(negedge clk); thr_empty = 0;
    @(negedge clk); thr_empty = 1;
    @(negedge clk);
  endtask

  task automatic pulse_err(input logic [3:0] e);
    @(negedge clk); line_err_ev = e;
    @(negedge clk); line_err_ev = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1 reset state
    chk("R1 irq", irq_out, 0);
    rd(3'd5, 8'h60, "R1 lsr");
    rd(3'd2, 8'h01, "R1 iir");
    rd(3'd1, 8'h00, "R1 ier");
    rd(3'd3, 8'h00, "R1 lcr");
    rd(3'd4, 8'h00, "R1 mcr");
    rd(3'd6, 8'h00, "R1 msr");
    chk("R1 divisor", divisor, 0);
    chk("R1 fifo_ctrl", fifo_ctrl, 0);
    // R9 line format and modem control
    wr(3'd3, 8'h1B);
    chk("R9 line_ctrl", line_ctrl, 8'h1B);
    rd(3'd3, 8'h1B, "R9 lcr read");
    wr(3'd4, 8'hFF);
    chk("R9 modem_ctrl", modem_ctrl, 6'h3F);
    rd(3'd4, 8'h3F, "R9 mcr read");
    // R3 divisor access
    wr(3'd3, 8'h83);
    wr(3'd0, 8'h34);
    chk("R3 no tx_load", tx_load, 0);
    wr(3'd1, 8'h12);
    chk("R3 divisor", divisor, 16'h1234);
    rd(3'd0, 8'h34, "R3 dll read");
    rd(3'd1, 8'h12, "R3 dlm read");
    wr(3'd3, 8'h03);
    rd(3'd1, 8'h00, "R3 ier untouched");
    // R4 enable register width
    wr(3'd1, 8'hFF);
    rd(3'd1, 8'h0F, "R4 ier upper zero");
    rd(3'd2, 8'h01, "R4 nothing pending");
    wr(3'd1, 8'h00);
    // R2 data path
    @(negedge clk); rx_byte = 8'hA5; rx_ready = 1;
    @(negedge clk);
    cs = 1; rd_en = 1; addr = 0;
    #0.5;
    chk("R2 rx read", rdata, 8'hA5);
    chk("R2 rx_pop", rx_pop, 1);
    @(negedge clk); cs = 0; rd_en = 0; rx_ready = 0;
    wr(3'd0, 8'h5C);
    chk("R2 tx_load", tx_load, 1);
    chk("R2 tx_byte", tx_byte, 8'h5C);
    @(negedge clk);
    chk("R2 tx_load one cycle", tx_load, 0);
    // R7 transmit-empty source
    wr(3'd1, 8'h02);
    thr_bounce();
    chk("R7 irq set", irq_out, 1);
    rd(3'd2, 8'h02, "R7 iir thre");
    rd(3'd2, 8'h01, "R7 cleared by iir read");
    thr_bounce();
    wr(3'd0, 8'h11);
    rd(3'd2, 8'h01, "R7 cleared by data write");
    // R6 priority with every source pending
    wr(3'd1, 8'h0F);
    thr_bounce();
    @(negedge clk); modem_in = 4'b0001; rx_ready = 1;
    pulse_err(4'b0010);
    rd(3'd2, 8'h06, "R6 line first");
    rd(3'd5, 8'h65, "R8 lsr parity");
    rd(3'd2, 8'h04, "R6 rx second");
    @(negedge clk); rx_ready = 0;
    rd(3'd2, 8'h02, "R6 thre third");
    rd(3'd2, 8'h00, "R6 modem last");
    rd(3'd6, 8'h11, "R10 msr cts");
    rd(3'd2, 8'h01, "R10 modem cleared");
    // R8 event coincident with a read survives
    @(negedge clk);
    cs = 1; rd_en = 1; addr = 5; line_err_ev = 4'b0001;
    @(negedge clk);
    cs = 0; rd_en = 0; line_err_ev = 0;
    rd(3'd5, 8'h62, "R8 overrun kept");
    pulse_err(4'b1100);
    rd(3'd5, 8'h78, "R8 frame and break");
    rd(3'd5, 8'h60, "R8 cleared");
    @(negedge clk); tx_empty = 0;
    rd(3'd5, 8'h20, "R8 temt live");
    @(negedge clk); tx_empty = 1;
    // R10 all lines change
    @(negedge clk); modem_in = 4'b1110;
    @(negedge clk);
    rd(3'd6, 8'hEF, "R10 all deltas");
    rd(3'd6, 8'hE0, "R10 deltas cleared");
    // R11 FIFO control
    wr(3'd2, 8'hC7);
    chk("R11 fifo_wr", fifo_wr, 1);
    chk("R11 fifo_ctrl", fifo_ctrl, 8'hC7);
    rd(3'd2, 8'h01, "R11 iir unaffected");
    rd(3'd7, 8'h00, "R11 addr7 zero");
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule